// File: doc/BRIEF.md
# Amplifier Protection Fault Supervisor

This block watches the health of a four-channel bridged audio power stage and decides when the stage must be silenced. It receives a digitized supply voltage in 0.1 V steps and a digitized junction temperature in whole degrees Celsius. Each arrives with its own valid strobe. It also receives one over-current comparator flag per channel, a charge-pump-good flag, a regulator-good flag and the active-low mute request from the system controller.

Each measured quantity passes through a hysteresis window, so a reading that sits near a limit cannot make the protection chatter. Over-current events set a latch that releases itself after a fixed hold time, and any new event during the hold restarts that time. All fault sources are combined into one fault flag, which also commands every output stage to high impedance. A combined active-low mute status reports muting caused by either the pin or a fault. An over-voltage also raises a forced-sleep request as load-dump protection.

Every threshold is a parameter in fixed-point units. The hold time is derived from a clock-frequency parameter. After reset the block assumes the worst case: it reports every measured fault as present until real readings show otherwise.

Top module: `amp_fault_supervisor`

## Requirements
- R1: During and directly after reset, with no measurement yet taken, fault = 1, stage_tristate = 1, sleep_req = 1 and mute_stat_n = 0.
- R2: A supply sample strictly above OV_SET (default 300, i.e. 30.0 V) sets the over-voltage condition at the next clock edge. A sample equal to OV_SET does not set it.
- R3: An active over-voltage condition clears only on a supply sample strictly below OV_CLR (default 260). A sample equal to OV_CLR keeps it active.
- R4: A supply sample strictly below UV_SET (default 81) sets the under-voltage condition. Once set, it clears only on a sample strictly above UV_CLR (default 95).
- R5: A signed temperature sample strictly above OT_SET (default 160 °C) sets the over-temperature condition. Once set, it clears only on a sample strictly below OT_CLR (default 130 °C).
- R6: Supply and temperature values presented while their valid strobe is low have no effect.
- R7: A high over-current flag on any channel, sampled at a clock edge, makes fault = 1 from that edge. The fault stays for exactly HOLD_CYC edges after the last edge at which any flag was high, where HOLD_CYC = CLK_HZ × HOLD_MS / 1000.
- R8: An over-current flag seen while the latch is still holding restarts the full HOLD_CYC count.
- R9: charge-pump-good low or regulator-good low makes fault = 1 in the same cycle, with no registering.
- R10: mute_stat_n = mute_req_n AND NOT fault, and stage_tristate equals fault. A low mute request alone does not raise fault.
- R11: sleep_req follows the over-voltage condition only. Under-voltage, over-temperature, over-current and the good flags never raise it.
- R12: The over-current latch is active out of reset and releases HOLD_CYC edges after reset is released, provided no flag has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsup_valid | input | 1 | Strobe: vsup holds a new sample |
| vsup | input | VW (12) | Supply voltage, unsigned, 0.1 V per LSB |
| temp_valid | input | 1 | Strobe: temp_c holds a new sample |
| temp_c | input | TW (10) | Junction temperature, signed, 1 °C per LSB |
| oc_flag | input | NCH (4) | Per-channel over-current comparator flags |
| cp_good | input | 1 | Charge-pump voltage adequate |
| reg_good | input | 1 | Internal regulator voltage adequate |
| mute_req_n | input | 1 | External mute request, active low |
| fault | output | 1 | Any protection condition active |
| mute_stat_n | output | 1 | Device muted when low, by pin or by fault |
| stage_tristate | output | 1 | Command all output stages to high impedance |
| sleep_req | output | 1 | Forced sleep request on over-voltage |

## Verification
The assertions check the rules that hold every cycle. They check the output combining, the immediate effect of a lost charge-pump or regulator flag, and that an over-current flag raises the fault on the next edge. They also check that a supply above the set threshold raises sleep, that an active over-voltage survives a sample at or above the clear level, and that sleep never moves without a supply strobe. The directed scenarios are needed to show the exact threshold boundaries on both sides of each hysteresis band and the exact length of the over-current hold. They also show that the hold restarts on a second event, and that the worst-case reset state is released by real readings.

// File: rtl/amp_fault_pkg.sv
// Package: shared types and helpers for the amplifier fault supervisor.
// Assumes the clock frequency and hold time give a cycle count that fits an int.
package amp_fault_pkg;

    // One bit per fault source feeding the combined fault flag
    typedef struct packed {
        logic over_volt;
        logic under_volt;
        logic over_temp;
        logic over_curr;
        logic pump_low;
        logic reg_low;
    } fault_src_t;

    // Number of clock cycles covering a delay given in milliseconds
    function automatic int hold_cycles(input longint clk_hz, input int ms);
        return int'((clk_hz * longint'(ms)) / 64'sd1000);
    endfunction

endpackage

// File: rtl/hyst_window.sv
// Module: hyst_window
// Holds one protection condition with separate set and clear thresholds.
// RISING=1: set when value > SET_TH, clear when value < CLR_TH.
// RISING=0: set when value < SET_TH, clear when value > CLR_TH.
// The state updates only on sample_en. It resets to the asserted state so
// that the condition is assumed present until a real sample arrives.
module hyst_window #(
    parameter int W      = 12,
    parameter int SET_TH = 300,
    parameter int CLR_TH = 260,
    parameter bit RISING = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic signed [W-1:0] value,
    output logic                active
);

    logic hit_set;
    logic hit_clr;
    int   v_int;

    assign v_int = int'(value);

    // Pick the comparison direction from the parameter
    generate
        if (RISING) begin : g_rise
            assign hit_set = v_int > SET_TH;
            assign hit_clr = v_int < CLR_TH;
        end else begin : g_fall
            assign hit_set = v_int < SET_TH;
            assign hit_clr = v_int > CLR_TH;
        end
    endgenerate

    // Condition state: set or clear only on a valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
        end else if (sample_en) begin
            if (hit_set)
                active <= 1'b1;
            else if (hit_clr)
                active <= 1'b0;
        end
    end

endmodule

// File: rtl/oc_latch.sv
// Module: oc_latch
// Latches any per-channel over-current flag and releases HOLD_CYC clock
// edges after the last edge at which a flag was seen. A new flag reloads
// the full count. Out of reset the latch is held for one full count.
// Assumes the flags are already synchronous to clk.
module oc_latch #(
    parameter int NCH      = 4,
    parameter int HOLD_CYC = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] oc_flag,
    output logic           active
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

    logic [CW-1:0] remain;

    // Hold counter: reload on any flag, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= HOLD_LD;
        else if (|oc_flag)
            remain <= HOLD_LD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

endmodule

// File: rtl/amp_fault_supervisor.sv
// Module: amp_fault_supervisor (top)
// Protection supervisor for a multi-channel bridged amplifier. It applies
// hysteresis windows to supply voltage (0.1 V units) and junction temperature
// (signed, 1 degC units), latches over-current events with a timed release,
// and combines all fault sources with the external mute request.
// Assumes every input is synchronous to clk.
module amp_fault_supervisor #(
    parameter int NCH     = 4,
    parameter int VW      = 12,
    parameter int TW      = 10,
    parameter int CLK_HZ  = 50_000_000,
    parameter int HOLD_MS = 600,
    parameter int OV_SET  = 300,
    parameter int OV_CLR  = 260,
    parameter int UV_SET  = 81,
    parameter int UV_CLR  = 95,
    parameter int OT_SET  = 160,
    parameter int OT_CLR  = 130
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vsup_valid,
    input  logic [VW-1:0]        vsup,
    input  logic                 temp_valid,
    input  logic signed [TW-1:0] temp_c,
    input  logic [NCH-1:0]       oc_flag,
    input  logic                 cp_good,
    input  logic                 reg_good,
    input  logic                 mute_req_n,
    output logic                 fault,
    output logic                 mute_stat_n,
    output logic                 stage_tristate,
    output logic                 sleep_req
);

    import amp_fault_pkg::*;

    localparam int HOLD_CYC = hold_cycles(longint'(CLK_HZ), HOLD_MS);

    logic signed [VW:0] vsup_s;
    fault_src_t         src;

    assign vsup_s = $signed({1'b0, vsup});

    // Over-voltage window on the supply
    hyst_window #(.W(VW + 1), .SET_TH(OV_SET), .CLR_TH(OV_CLR), .RISING(1'b1)) u_ov (
        .clk(clk), .rst_n(rst_n), .sample_en(vsup_valid),
        .value(vsup_s), .active(src.over_volt)
    );

    // Under-voltage window on the supply
    hyst_window #(.W(VW + 1), .SET_TH(UV_SET), .CLR_TH(UV_CLR), .RISING(1'b0)) u_uv (
        .clk(clk), .rst_n(rst_n), .sample_en(vsup_valid),
        .value(vsup_s), .active(src.under_volt)
    );

    // Over-temperature window on the junction temperature
    hyst_window #(.W(TW), .SET_TH(OT_SET), .CLR_TH(OT_CLR), .RISING(1'b1)) u_ot (
        .clk(clk), .rst_n(rst_n), .sample_en(temp_valid),
        .value(temp_c), .active(src.over_temp)
    );

    // Timed over-current latch over all channels
    oc_latch #(.NCH(NCH), .HOLD_CYC(HOLD_CYC)) u_oc (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .active(src.over_curr)
    );

    // Supply-health flags enter the fault set directly
    assign src.pump_low = ~cp_good;
    assign src.reg_low  = ~reg_good;

    // Output combining: any source faults, tristates and mutes
    always_comb begin
        fault          = |src;
        stage_tristate = fault;
        mute_stat_n    = mute_req_n & ~fault;
        sleep_req      = src.over_volt;
    end

endmodule

// File: rtl/amp_fault_supervisor_chk.sv
// Module: amp_fault_supervisor_chk
// Cycle-level checks on the supervisor's ports, attached by bind.
module amp_fault_supervisor_chk #(
    parameter int NCH    = 4,
    parameter int VW     = 12,
    parameter int OV_SET = 300,
    parameter int OV_CLR = 260
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vsup_valid,
    input logic [VW-1:0]  vsup,
    input logic [NCH-1:0] oc_flag,
    input logic           cp_good,
    input logic           reg_good,
    input logic           mute_req_n,
    input logic           fault,
    input logic           mute_stat_n,
    input logic           stage_tristate,
    input logic           sleep_req
);

    AST_OV_ABOVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (vsup_valid && int'(vsup) > OV_SET) |=> sleep_req); // R2
    AST_OV_HOLDS_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (vsup_valid && int'(vsup) >= OV_CLR && sleep_req) |=> sleep_req); // R3
    AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !vsup_valid |=> $stable(sleep_req)); // R6
    AST_OC_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_flag) |=> fault); // R7
    AST_GOOD_LOSS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_good || !reg_good) |-> fault); // R9
    AST_PIN_MUTE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_req_n |-> !mute_stat_n); // R10
    AST_FAULT_MUTES_AND_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mute_stat_n && stage_tristate)); // R10
    AST_SLEEP_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> fault); // R11

endmodule

bind amp_fault_supervisor amp_fault_supervisor_chk #(
    .NCH(NCH), .VW(VW), .OV_SET(OV_SET), .OV_CLR(OV_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vsup_valid(vsup_valid), .vsup(vsup),
    .oc_flag(oc_flag), .cp_good(cp_good), .reg_good(reg_good),
    .mute_req_n(mute_req_n), .fault(fault), .mute_stat_n(mute_stat_n),
    .stage_tristate(stage_tristate), .sleep_req(sleep_req)
);

// File: tb/amp_fault_supervisor_test.sv
// Directed bench for amp_fault_supervisor. Inputs change on the falling edge
// and outputs are read on the falling edge.
module amp_fault_supervisor_test;

    localparam int NCH    = 4;
    localparam int VW     = 12;
    localparam int TW     = 10;
    localparam int CLK_HZ = 10_000;
    localparam int HOLD   = CLK_HZ * 600 / 1000;   // 6000 edges

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 vsup_valid;
    logic [VW-1:0]        vsup;
    logic                 temp_valid;
    logic signed [TW-1:0] temp_c;
    logic [NCH-1:0]       oc_flag;
    logic                 cp_good;
    logic                 reg_good;
    logic                 mute_req_n;
    logic                 fault;
    logic                 mute_stat_n;
    logic                 stage_tristate;
    logic                 sleep_req;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    amp_fault_supervisor #(.NCH(NCH), .VW(VW), .TW(TW), .CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .vsup_valid(vsup_valid), .vsup(vsup),
        .temp_valid(temp_valid), .temp_c(temp_c), .oc_flag(oc_flag),
        .cp_good(cp_good), .reg_good(reg_good), .mute_req_n(mute_req_n),
        .fault(fault), .mute_stat_n(mute_stat_n),
        .stage_tristate(stage_tristate), .sleep_req(sleep_req)
    );

    // Compare {fault, mute_stat_n, stage_tristate, sleep_req}
    task automatic check_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {fault, mute_stat_n, stage_tristate, sleep_req};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {fault,mute_n,tri,sleep} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas_v(input int v);
        vsup = VW'(v); vsup_valid = 1'b1;
        step(1);
        vsup_valid = 1'b0;
    endtask

    task automatic meas_t(input int t);
        temp_c = TW'(t); temp_valid = 1'b1;
        step(1);
        temp_valid = 1'b0;
    endtask

    // R1, R12: worst-case reset state and timed release of the OC latch
    task automatic t_reset;
        rst_n = 1'b0; vsup_valid = 1'b0; vsup = VW'(144); temp_valid = 1'b0;
        temp_c = TW'(25); oc_flag = '0; cp_good = 1'b1; reg_good = 1'b1;
        mute_req_n = 1'b1;
        step(4);
        check_out("R1 in reset", 4'b1011);
        rst_n = 1'b1;
        step(1);
        check_out("R1 after release", 4'b1011);
        vsup = VW'(144); vsup_valid = 1'b1;
        temp_c = TW'(25); temp_valid = 1'b1;
        step(1);
        vsup_valid = 1'b0; temp_valid = 1'b0;
        check_out("R12 latch still held", 4'b1010);
        step(HOLD - 3);
        check_out("R12 last held edge", 4'b1010);
        step(1);
        check_out("R12 released", 4'b0100);
    endtask

    // R2, R3, R6, R11: over-voltage window and load-dump sleep
    task automatic t_over_volt;
        meas_v(300);
        check_out("R2 equal to set", 4'b0100);
        meas_v(301);
        check_out("R2 above set", 4'b1011);
        meas_v(260);
        check_out("R3 equal to clear", 4'b1011);
        meas_v(259);
        check_out("R3 below clear", 4'b0100);
        vsup = VW'(350);
        step(3);
        check_out("R6 no strobe supply", 4'b0100);
        vsup = VW'(144);
    endtask

    // R4, R11: under-voltage window, no sleep
    task automatic t_under_volt;
        meas_v(81);
        check_out("R4 equal to set", 4'b0100);
        meas_v(80);
        check_out("R4 R11 below set", 4'b1010);
        meas_v(95);
        check_out("R4 equal to clear", 4'b1010);
        meas_v(96);
        check_out("R4 above clear", 4'b0100);
        meas_v(144);
    endtask

    // R5, R6: over-temperature window
    task automatic t_over_temp;
        meas_t(160);
        check_out("R5 equal to set", 4'b0100);
        meas_t(161);
        check_out("R5 above set", 4'b1010);
        meas_t(130);
        check_out("R5 equal to clear", 4'b1010);
        meas_t(129);
        check_out("R5 below clear", 4'b0100);
        temp_c = TW'(200);
        step(3);
        check_out("R6 no strobe temp", 4'b0100);
        meas_t(-20);
        check_out("R5 negative temp", 4'b0100);
    endtask

    // R7: single over-current event, exact hold length
    task automatic t_oc_single;
        oc_flag = 4'b0100;
        step(1);
        oc_flag = '0;
        check_out("R7 set on flag", 4'b1010);
        step(HOLD - 1);
        check_out("R7 last held edge", 4'b1010);
        step(1);
        check_out("R7 released", 4'b0100);
    endtask

    // R8: a second event inside the hold restarts the count
    task automatic t_oc_restart;
        oc_flag = 4'b0001;
        step(1);
        oc_flag = '0;
        step(3000);
        oc_flag = 4'b1000;
        step(1);
        oc_flag = '0;
        step(HOLD - 1);
        check_out("R8 held after restart", 4'b1010);
        step(1);
        check_out("R8 released after restart", 4'b0100);
    endtask

    // R9: charge-pump and regulator flags act without delay
    task automatic t_good_flags;
        cp_good = 1'b0;
        #1;
        check_out("R9 pump low", 4'b1010);
        step(1);
        cp_good = 1'b1;
        #1;
        check_out("R9 pump back", 4'b0100);
        reg_good = 1'b0;
        #1;
        check_out("R9 regulator low", 4'b1010);
        step(1);
        reg_good = 1'b1;
        #1;
        check_out("R9 regulator back", 4'b0100);
        step(1);
    endtask

    // R10: pin mute reaches status without raising fault
    task automatic t_pin_mute;
        mute_req_n = 1'b0;
        step(1);
        check_out("R10 pin mute", 4'b0000);
        cp_good = 1'b0;
        step(1);
        check_out("R10 pin mute with fault", 4'b1010);
        cp_good = 1'b1;
        mute_req_n = 1'b1;
        step(1);
        check_out("R10 unmuted", 4'b0100);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_over_volt();
        t_under_volt();
        t_over_temp();
        t_oc_single();
        t_oc_restart();
        t_good_flags();
        t_pin_mute();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule